// File: doc/BRIEF.md
# Parallel DMA interface controller

This block moves blocks of 16-bit words between host memory and an external parallel peripheral. The host sees four 16-bit registers: a word count, a bus address, a command/status word and a data word. Software loads the count with minus the number of words and loads the start address. A command/status write sets the direction and three function lines to the peripheral, and a later write with the start bit launches the transfer.

While a transfer runs, the block issues one word request at a time on a request/acknowledge memory port. Each acknowledged word moves the count one step toward zero and the 18-bit address forward by two bytes. When the count reaches zero, the block stops, sets READY and raises an interrupt if enabled. A missing acknowledge sets memory-error flags. A maintenance bit aborts the transfer. Peripheral status lines and an attention input are reported in the status word, and a rising attention can also interrupt.

Top module: `par_dma_ctrl`

## Requirements
- R1: After reset, the word count and bus address read 0, the status word reads 0x0080 (READY only) while the peripheral inputs are low, and irq and mem_req are low.
- R2: The register address selects 0 = word count, 1 = bus address, 2 = command/status, 3 = data. Reading 3 returns pdata_in and writing 3 loads pdata_out. Writes to 0 and 1 are ignored while a transfer is active.
- R3: Each acknowledged word adds 1 to the word count modulo 2^16. The transfer ends on the acknowledge that brings the count to zero, so a start value of -N moves N words.
- R4: The memory address is {status bits 5:4, bus address}. It advances by 2 per acknowledged word, and a carry out of bit 15 increments status bits 5:4.
- R5: On completion READY (status bit 7) is set, the word count reads 0 and mem_req is low from the next cycle.
- R6: Every status write loads fn_out from bits 3:1, interrupt enable from bit 6 and maintenance from bit 12, whether or not bit 0 is set. A write with bit 0 set while idle and not in maintenance clears READY and starts a transfer. With a zero count, no words move and it only signals completion.
- R7: While maintenance (bit 12) is set, an active transfer stops within one cycle with READY set and the count left as it was, and start requests are ignored.
- R8: A pending interrupt is set when a transfer ends (completion, timeout, abort or zero-count start) or when attn_in rises. Any status write clears it unless an event occurs in the same cycle. irq equals pending AND enable.
- R9: If a request is not acknowledged for ACK_TIMEOUT (16) consecutive cycles, the transfer stops and status bits 14 (no memory) and 15 (error) and READY are set.
- R10: A status write with bit 15 = 1 clears bits 14 and 15. A write with bit 15 = 0 leaves them unchanged.
- R11: Bit 2 of the starting write picks the direction. With 1, memory is read (mem_we low) and each acknowledged word is loaded into pdata_out. With 0, memory is written (mem_we high) with pdata_in.
- R12: Status bits 11:9 show pstat_in[2:0] and bit 13 shows attn_in delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Memory write when high |
| mem_addr | output | 18 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| fn_out | output | 3 | Function lines to the peripheral |
| pdata_out | output | 16 | Output data word to the peripheral |
| pdata_in | input | 16 | Input data word from the peripheral |
| pstat_in | input | 3 | Peripheral status lines |
| attn_in | input | 1 | Peripheral attention |
| irq | output | 1 | Interrupt request |

## Verification
A wrong count or address shows on mem_addr in the cycle after the first faulty step, and on the count readback at once. A wrong end-of-transfer decision shows as mem_req staying high or falling early, one cycle after the deciding acknowledge. Wrong flag or pending-interrupt state shows on irq or on the status readback in the cycle after the event. A reference model compares every output each clock, so the first divergent cycle is reported.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  typedef enum logic [1:0] {
    RSEL_WCNT  = 2'd0,
    RSEL_BADDR = 2'd1,
    RSEL_CSR   = 2'd2,
    RSEL_DATA  = 2'd3
  } rsel_e;

  typedef enum logic {
    XS_IDLE = 1'b0,
    XS_RUN  = 1'b1
  } xstate_e;

  localparam int B_GO    = 0;
  localparam int B_FN_LO = 1;
  localparam int B_DIR   = 2;
  localparam int B_XA_LO = 4;
  localparam int B_IE    = 6;
  localparam int B_RDY   = 7;
  localparam int B_PS_LO = 9;
  localparam int B_MAINT = 12;
  localparam int B_ATTN  = 13;
  localparam int B_NEX   = 14;
  localparam int B_ERR   = 15;
endpackage

// File: rtl/pdma_addr_step.sv
module pdma_addr_step #(
  parameter int DW = 16,
  parameter int XW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_cnt,
  input  logic          ld_base,
  input  logic          ld_ext,
  input  logic [DW-1:0] wdata,
  input  logic [XW-1:0] ext_in,
  input  logic          step,
  output logic [DW-1:0] cnt,
  output logic [DW-1:0] base,
  output logic [XW-1:0] ext,
  output logic          last
);
  localparam int AW = DW + XW;
  localparam logic [AW-1:0] BYTES_PER_WORD = AW'(2);

  logic [DW-1:0] cnt_n;
  logic [AW-1:0] addr_q, addr_n;

  assign base = addr_q[DW-1:0];
  assign ext  = addr_q[AW-1:DW];
  assign last = (cnt == {DW{1'b1}});

  always_comb begin
    cnt_n  = cnt;
    addr_n = addr_q;
    if (ld_cnt)
      cnt_n = wdata;
    else if (step)
      cnt_n = cnt + DW'(1);
    if (step) begin
      addr_n = addr_q + BYTES_PER_WORD;
    end else begin
      if (ld_base) addr_n[DW-1:0] = wdata;
      if (ld_ext)  addr_n[AW-1:DW] = ext_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      addr_q <= '0;
    end else begin
      cnt    <= cnt_n;
      addr_q <= addr_n;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt == $past(cnt) + DW'(1)); // R3
  AST_ADDR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> {ext, base} == $past({ext, base}) + BYTES_PER_WORD); // R4
endmodule

// File: rtl/pdma_xfer_ctrl.sv
module pdma_xfer_ctrl
  import pdma_pkg::*;
#(
  parameter int ACK_TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  input  logic mem_ack,
  input  logic last,
  output logic busy,
  output logic req,
  output logic step,
  output logic done,
  output logic tmo,
  output logic stop_evt
);
  localparam int TW = $clog2(ACK_TIMEOUT + 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(ACK_TIMEOUT - 1);

  xstate_e        st_q, st_n;
  logic [TW-1:0]  wait_q, wait_n;

  assign busy     = (st_q == XS_RUN);
  assign req      = busy & ~abort;
  assign step     = req & mem_ack;
  assign done     = step & last;
  assign tmo      = req & ~mem_ack & (wait_q == TMO_LAST);
  assign stop_evt = done | tmo | (busy & abort);

  always_comb begin
    st_n   = st_q;
    wait_n = wait_q;
    case (st_q)
      XS_IDLE: begin
        wait_n = '0;
        if (start) st_n = XS_RUN;
      end
      XS_RUN: begin
        if (stop_evt) begin
          st_n   = XS_IDLE;
          wait_n = '0;
        end else if (mem_ack) begin
          wait_n = '0;
        end else begin
          wait_n = wait_q + TW'(1);
        end
      end
      default: st_n = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= XS_IDLE;
      wait_q <= '0;
    end else begin
      st_q   <= st_n;
      wait_q <= wait_n;
    end
  end

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !busy); // R5
  AST_START_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R6
endmodule

// File: rtl/par_dma_ctrl.sv
module par_dma_ctrl
  import pdma_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int XADDR_W     = 2,
  parameter int FN_W        = 3,
  parameter int ACK_TIMEOUT = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic [1:0]                 reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic [DATA_W+XADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]          mem_wdata,
  input  logic [DATA_W-1:0]          mem_rdata,
  input  logic                       mem_ack,
  output logic [FN_W-1:0]            fn_out,
  output logic [DATA_W-1:0]          pdata_out,
  input  logic [DATA_W-1:0]          pdata_in,
  input  logic [FN_W-1:0]            pstat_in,
  input  logic                       attn_in,
  output logic                       irq
);
  rsel_e sel;
  logic  csr_wr, go_req, start, zero_go, end_evt, attn_rise;
  logic  busy, req, step, done, tmo, stop_evt, last;
  logic  [DATA_W-1:0]  wcnt, baddr;
  logic  [XADDR_W-1:0] xaddr;

  logic [FN_W-1:0]   fn_q, fn_n;
  logic              ie_q, ie_n, maint_q, maint_n;
  logic              ready_q, ready_n, err_q, err_n, nex_q, nex_n;
  logic              pend_q, pend_n, dir_q, dir_n, attn_q;
  logic [DATA_W-1:0] dout_q, dout_n;
  logic              unused_wbits;

  assign sel       = rsel_e'(reg_addr);
  assign csr_wr    = reg_wr && (sel == RSEL_CSR);
  assign go_req    = csr_wr && reg_wdata[B_GO] && !reg_wdata[B_MAINT] && !maint_q && !busy;
  assign start     = go_req && (wcnt != '0);
  assign zero_go   = go_req && (wcnt == '0);
  assign attn_rise = attn_in && !attn_q;
  assign end_evt   = stop_evt || zero_go;
  assign unused_wbits = ^{reg_wdata[B_RDY +: 2], reg_wdata[B_PS_LO +: 3], reg_wdata[B_ATTN +: 2]};

  pdma_addr_step #(.DW(DATA_W), .XW(XADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_cnt  (reg_wr && (sel == RSEL_WCNT) && !busy),
    .ld_base (reg_wr && (sel == RSEL_BADDR) && !busy),
    .ld_ext  (csr_wr && !busy),
    .wdata   (reg_wdata),
    .ext_in  (reg_wdata[B_XA_LO +: XADDR_W]),
    .step    (step),
    .cnt     (wcnt),
    .base    (baddr),
    .ext     (xaddr),
    .last    (last)
  );

  pdma_xfer_ctrl #(.ACK_TIMEOUT(ACK_TIMEOUT)) u_xfer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .abort    (maint_q),
    .mem_ack  (mem_ack),
    .last     (last),
    .busy     (busy),
    .req      (req),
    .step     (step),
    .done     (done),
    .tmo      (tmo),
    .stop_evt (stop_evt)
  );

  always_comb begin
    fn_n    = fn_q;
    ie_n    = ie_q;
    maint_n = maint_q;
    ready_n = ready_q;
    err_n   = err_q;
    nex_n   = nex_q;
    pend_n  = pend_q;
    dir_n   = dir_q;
    dout_n  = dout_q;
    if (csr_wr) begin
      fn_n    = reg_wdata[B_FN_LO +: FN_W];
      ie_n    = reg_wdata[B_IE];
      maint_n = reg_wdata[B_MAINT];
      pend_n  = 1'b0;
      if (reg_wdata[B_ERR]) begin
        err_n = 1'b0;
        nex_n = 1'b0;
      end
    end
    if (start) begin
      ready_n = 1'b0;
      dir_n   = reg_wdata[B_DIR];
    end
    if (stop_evt) ready_n = 1'b1;
    if (tmo) begin
      err_n = 1'b1;
      nex_n = 1'b1;
    end
    if (end_evt || attn_rise) pend_n = 1'b1;
    if (reg_wr && (sel == RSEL_DATA)) dout_n = reg_wdata;
    if (step && dir_q) dout_n = mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_q    <= '0;
      ie_q    <= 1'b0;
      maint_q <= 1'b0;
      ready_q <= 1'b1;
      err_q   <= 1'b0;
      nex_q   <= 1'b0;
      pend_q  <= 1'b0;
      dir_q   <= 1'b0;
      dout_q  <= '0;
      attn_q  <= 1'b0;
    end else begin
      fn_q    <= fn_n;
      ie_q    <= ie_n;
      maint_q <= maint_n;
      ready_q <= ready_n;
      err_q   <= err_n;
      nex_q   <= nex_n;
      pend_q  <= pend_n;
      dir_q   <= dir_n;
      dout_q  <= dout_n;
      attn_q  <= attn_in;
    end
  end

  always_comb begin
    case (sel)
      RSEL_WCNT:  reg_rdata = wcnt;
      RSEL_BADDR: reg_rdata = baddr;
      RSEL_CSR: begin
        reg_rdata = '0;
        reg_rdata[B_FN_LO +: FN_W]    = fn_q;
        reg_rdata[B_XA_LO +: XADDR_W] = xaddr;
        reg_rdata[B_IE]               = ie_q;
        reg_rdata[B_RDY]              = ready_q;
        reg_rdata[B_PS_LO +: FN_W]    = pstat_in;
        reg_rdata[B_MAINT]            = maint_q;
        reg_rdata[B_ATTN]             = attn_q;
        reg_rdata[B_NEX]              = nex_q;
        reg_rdata[B_ERR]              = err_q;
      end
      default:    reg_rdata = pdata_in;
    endcase
  end

  assign mem_req   = req;
  assign mem_we    = req & ~dir_q;
  assign mem_addr  = {xaddr, baddr};
  assign mem_wdata = pdata_in;
  assign fn_out    = fn_q;
  assign pdata_out = dout_q;
  assign irq       = pend_q & ie_q;

  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (ready_q && wcnt == '0 && !mem_req)); // R5
  AST_TMO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> (err_q && nex_q && ready_q && !busy)); // R9
  AST_MAINT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    maint_q |=> !busy); // R7
  AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && !end_evt && !attn_rise) |=> !irq); // R8
  AST_ERR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && reg_wdata[B_ERR] && !tmo) |=> (!err_q && !nex_q)); // R10
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_wr && !tmo) |=> (err_q == $past(err_q))); // R10
endmodule

// File: tb/par_dma_ctrl_bench.sv
`timescale 1ns/1ps
module par_dma_ctrl_bench;
  localparam int T = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [17:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata, pdata_out, pdata_in;
  logic [2:0]  fn_out, pstat_in;
  logic        attn_in, irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int lat    = 0;
  int lat_cnt = 0;

  always #4 clk = ~clk;

  par_dma_ctrl u_par_dma_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .fn_out(fn_out),
    .pdata_out(pdata_out), .pdata_in(pdata_in), .pstat_in(pstat_in),
    .attn_in(attn_in), .irq(irq)
  );

  // reference model state
  logic        m_busy, m_ready, m_err, m_nex, m_ie, m_maint, m_dir, m_pend, m_attnq;
  logic [2:0]  m_fn;
  logic [15:0] m_wcr, m_dout;
  logic [17:0] m_a;
  int          m_wait;

  function automatic logic [15:0] mem_word(input logic [17:0] a);
    return a[16:1] ^ 16'hA5A5;
  endfunction

  function automatic logic [15:0] m_csr();
    return {m_err, m_nex, m_attnq, m_maint, pstat_in, 1'b0, m_ready, m_ie, m_a[17:16], m_fn, 1'b0};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_ready = 1; m_err = 0; m_nex = 0; m_ie = 0; m_maint = 0;
      m_dir = 0; m_pend = 0; m_attnq = 0; m_fn = 0; m_wcr = 0; m_dout = 0;
      m_a = 0; m_wait = 0;
    end else begin
      logic o_busy, o_maint, csr_wr, go, ev, arise;
      logic [15:0] o_wcr;
      logic [17:0] o_a;
      o_busy = m_busy; o_maint = m_maint; o_wcr = m_wcr; o_a = m_a;
      csr_wr = reg_wr && reg_addr == 2'd2;
      ev = 0;
      if (reg_wr && reg_addr == 2'd0 && !o_busy) m_wcr = reg_wdata;
      if (reg_wr && reg_addr == 2'd1 && !o_busy) m_a[15:0] = reg_wdata;
      if (reg_wr && reg_addr == 2'd3) m_dout = reg_wdata;
      if (csr_wr) begin
        m_fn = reg_wdata[3:1]; m_ie = reg_wdata[6]; m_maint = reg_wdata[12];
        if (!o_busy) m_a[17:16] = reg_wdata[5:4];
        if (reg_wdata[15]) begin m_err = 0; m_nex = 0; end
      end
      go = csr_wr && reg_wdata[0] && !reg_wdata[12] && !o_maint && !o_busy;
      if (go) begin
        if (o_wcr == 0) ev = 1;
        else begin m_busy = 1; m_ready = 0; m_dir = reg_wdata[2]; m_wait = 0; end
      end
      if (o_busy) begin
        if (o_maint) begin
          m_busy = 0; m_ready = 1; ev = 1;
        end else if (mem_ack) begin
          m_wcr = o_wcr + 16'd1; m_a = o_a + 18'd2; m_wait = 0;
          if (m_dir) m_dout = mem_word(o_a);
          if (m_wcr == 0) begin m_busy = 0; m_ready = 1; ev = 1; end
        end else if (m_wait == T - 1) begin
          m_busy = 0; m_ready = 1; m_err = 1; m_nex = 1; ev = 1;
        end else m_wait++;
      end
      arise = attn_in && !m_attnq;
      m_attnq = attn_in;
      if (ev || arise) m_pend = 1;
      else if (csr_wr) m_pend = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [15:0] er;
      case (reg_addr)
        2'd0: er = m_wcr;
        2'd1: er = m_a[15:0];
        2'd2: er = m_csr();
        default: er = pdata_in;
      endcase
      chk("R5 mem_req", {31'd0, mem_req}, {31'd0, m_busy && !m_maint});
      chk("R11 mem_we", {31'd0, mem_we}, {31'd0, m_busy && !m_maint && !m_dir});
      chk("R4 mem_addr", {14'd0, mem_addr}, {14'd0, m_a});
      chk("R8 irq", {31'd0, irq}, {31'd0, m_pend && m_ie});
      chk("R6 fn_out", {29'd0, fn_out}, {29'd0, m_fn});
      chk("R11 pdata_out", {16'd0, pdata_out}, {16'd0, m_dout});
      chk("R2 rdata", {16'd0, reg_rdata}, {16'd0, er});
      chk("R11 mem_wdata", {16'd0, mem_wdata}, {16'd0, pdata_in});
    end
  end

  // memory responder
  always @(negedge clk) begin
    #1;
    mem_rdata = mem_word(mem_addr);
    if (mem_req) begin
      if (lat_cnt >= lat) begin mem_ack = 1; lat_cnt = 0; end
      else begin mem_ack = 0; lat_cnt++; end
    end else begin
      mem_ack = 0; lat_cnt = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); #1;
    reg_addr = a;
    #2 v = reg_rdata;
  endtask

  task automatic wait_ready();
    logic [15:0] v;
    for (int i = 0; i < 300; i++) begin
      rd(2'd2, v);
      if (v[7]) break;
    end
  endtask

  initial begin
    logic [15:0] v;
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; mem_ack = 0; mem_rdata = 0;
    pdata_in = 16'h1357; pstat_in = 0; attn_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(2'd2, v); chk("R1 csr", {16'd0, v}, 32'h0080);
    rd(2'd0, v); chk("R1 wcr", {16'd0, v}, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);

    // outbound transfer across the 64K boundary
    wr(2'd0, 16'hFFFD);
    wr(2'd1, 16'hFFFC);
    wr(2'd2, 16'h0056);
    chk("R6 fn settles without start", {29'd0, fn_out}, 32'd3);
    chk("R6 no start", {31'd0, mem_req}, 32'd0);
    lat = 1;
    wr(2'd2, 16'h0057);
    wait_ready();
    rd(2'd0, v); chk("R3 count ends at zero", {16'd0, v}, 32'h0);
    rd(2'd1, v); chk("R4 address low", {16'd0, v}, 32'h0002);
    rd(2'd2, v); chk("R4 extension carry", {16'd0, v}, 32'h00E6);
    chk("R11 last word out", {16'd0, pdata_out}, 32'hA5A5);
    chk("R8 completion irq", {31'd0, irq}, 32'd1);
    wr(2'd2, 16'h0040);
    chk("R8 irq acknowledged", {31'd0, irq}, 32'd0);

    // inbound transfer
    lat = 0;
    wr(2'd0, 16'hFFFE);
    wr(2'd1, 16'h0100);
    wr(2'd2, 16'h0041);
    wait_ready();
    rd(2'd1, v); chk("R11 inbound address", {16'd0, v}, 32'h0104);
    rd(2'd0, v); chk("R3 inbound count", {16'd0, v}, 32'h0);

    // timeout
    lat = 1000;
    wr(2'd0, 16'hFFFF);
    wr(2'd2, 16'h0041);
    repeat (T + 6) @(negedge clk);
    rd(2'd2, v); chk("R9 timeout flags", {16'd0, v}, 32'hC0C0);
    rd(2'd0, v); chk("R9 count untouched", {16'd0, v}, 32'hFFFF);
    wr(2'd2, 16'h0040);
    rd(2'd2, v); chk("R10 zero leaves flags", {16'd0, v}, 32'hC0C0);
    wr(2'd2, 16'h8040);
    rd(2'd2, v); chk("R10 one clears flags", {16'd0, v}, 32'h00C0);

    // maintenance abort
    wr(2'd0, 16'hFFFC);
    wr(2'd2, 16'h0041);
    wr(2'd0, 16'h1234);
    rd(2'd2, v); chk("R6 start clears ready", {16'd0, v}, 32'h0040);
    wr(2'd2, 16'h1040);
    @(negedge clk);
    rd(2'd2, v); chk("R7 abort sets ready", {16'd0, v}, 32'h10C0);
    rd(2'd0, v); chk("R2 count write ignored when busy", {16'd0, v}, 32'hFFFC);
    wr(2'd2, 16'h1041);
    @(negedge clk);
    chk("R7 start ignored", {31'd0, mem_req}, 32'd0);
    wr(2'd2, 16'h0040);

    // attention and peripheral status
    attn_in = 1;
    @(negedge clk); @(negedge clk);
    chk("R8 attention irq", {31'd0, irq}, 32'd1);
    pstat_in = 3'b101;
    rd(2'd2, v); chk("R12 status lines", {16'd0, v}, 32'h2AC0);
    wr(2'd2, 16'h0040);
    @(negedge clk);
    chk("R8 level attention no rearm", {31'd0, irq}, 32'd0);
    attn_in = 0; pstat_in = 0;

    // zero-count start
    lat = 0;
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h0041);
    chk("R6 zero count signals completion", {31'd0, irq}, 32'd1);
    chk("R6 zero count moves nothing", {31'd0, mem_req}, 32'd0);

    // data register
    wr(2'd3, 16'hBEEF);
    chk("R2 data write", {16'd0, pdata_out}, 32'hBEEF);
    rd(2'd3, v); chk("R2 data read", {16'd0, v}, 32'h1357);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule